// File: doc/BRIEF.md
# Parallel-in serial-out shifter with level-sensitive load

This block is an eight-stage shift register that takes a word on its parallel inputs and sends it out one bit at a time. Loading is not tied to the clock: while the active-low load control is held low, every stage is forced straight to its parallel input bit through its own set and clear gating. The stages keep following the inputs for as long as the control stays low, and clock edges in that time do nothing.

Once the load control goes high, every rising edge of the effective clock moves the word one place toward the output. The serial input enters the first stage, and the bit that was in the last stage is dropped. The effective clock is the clock input ORed with the clock-inhibit input, so either pin can hold the register still. The last stage drives the serial output, and its complement is also brought out.

Top module: `par_ser_shifter`

## Requirements
- R1: While `load_n` is low, `q_out` equals `par_in[7]` at once, with no clock edge needed. Bit `par_in[0]` feeds stage 1, and `par_in[7]` feeds stage 8, which drives the output.
- R2: While `load_n` stays low, the stages follow every change of `par_in`, and rising clock edges have no effect on them.
- R3: With `load_n` high and `clk_inhibit` low, each rising edge of `clk` loads `ser_in` into stage 1 and moves stage i into stage i+1. The old value of stage 8 is lost.
- R4: With `load_n` high, `par_in` has no effect on the contents.
- R5: While `clk_inhibit` is high, a rising edge of `clk` does not change the contents. The effective clock is `clk` OR `clk_inhibit`, and `clk_inhibit` may change only while `clk` is high.
- R6: `q_out_n` is always the inverse of `q_out`.
- R7: Raising `load_n` while `clk` is high keeps the loaded word unchanged until the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edges shift |
| clk_inhibit | input | 1 | High blocks shifting; ORed with clk |
| load_n | input | 1 | Low loads asynchronously, high shifts |
| ser_in | input | 1 | Serial input to stage 1 |
| par_in | input | 8 | Parallel word; bit 0 goes to stage 1 |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Inverse of last stage |

## Verification
The asynchronous load and the clocked shift can meet in the same cycle, because the clock keeps running while the load control is low. The bench holds the load control low across several clock edges while it toggles the serial input and changes the parallel word in the middle of the load. It passes when the output follows the parallel word alone. A second overlap comes at the release of the load, which happens while the clock is high. The output must keep the loaded bit until the next rising edge, and only then take up the shifted sequence.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_WIDTH = 8;

    // Level of load_n that selects each mode.
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } psr_mode_e;

    function automatic logic load_active(input logic ctl);
        return ctl == MODE_LOAD;
    endfunction
endpackage

// File: rtl/psr_clk_merge.sv
module psr_clk_merge (
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_eff
);
    // Either pin held high keeps the effective clock from rising.
    assign clk_eff = clk_a | clk_b;
endmodule

// File: rtl/psr_load_gate.sv
module psr_load_gate #(
    parameter int WIDTH = psr_pkg::PSR_WIDTH
) (
    input  logic             load_n,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] set_v,
    output logic [WIDTH-1:0] clr_v
);
    import psr_pkg::*;

    logic active;
    assign active = load_active(load_n);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_gate
            assign set_v[g] = active &  word[g];
            assign clr_v[g] = active & ~word[g];
        end
    endgenerate
endmodule

// File: rtl/psr_stage.sv
module psr_stage (
    input  logic clk_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
        if (clr_i) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/par_ser_shifter.sv
module par_ser_shifter #(
    parameter int WIDTH = psr_pkg::PSR_WIDTH
) (
    input  logic             clk,
    input  logic             clk_inhibit,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_out,
    output logic             q_out_n
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } shift_t;

    shift_t           nxt_d;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] set_v;
    logic [WIDTH-1:0] clr_v;
    logic             clk_eff;

    psr_clk_merge u_clk (
        .clk_a  (clk),
        .clk_b  (clk_inhibit),
        .clk_eff(clk_eff)
    );

    psr_load_gate #(.WIDTH(WIDTH)) u_gate (
        .load_n(load_n),
        .word  (par_in),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    // Next value of every stage for a shift edge.
    always_comb begin
        nxt_d.stages = {stage_q[LAST-1:0], ser_in};
    end

    genvar s;
    generate
        for (s = 0; s < WIDTH; s++) begin : g_stage
            psr_stage u_stage (
                .clk_i(clk_eff),
                .set_i(set_v[s]),
                .clr_i(clr_v[s]),
                .d_i  (nxt_d.stages[s]),
                .q_o  (stage_q[s])
            );
        end
    endgenerate

    assign q_out   = stage_q[LAST];
    assign q_out_n = ~stage_q[LAST];
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
    parameter int WIDTH = psr_pkg::PSR_WIDTH
) (
    input logic             clk,
    input logic             clk_inhibit,
    input logic             load_n,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stage_q,
    input logic             q_out,
    input logic             q_out_n
);
    // No reset exists; checks start once a load has been seen.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (!load_n) armed <= 1'b1;
    end

    assert_load_out_R1: assert property (@(posedge clk) disable iff (!armed)
        !load_n |-> (q_out == par_in[WIDTH-1]));

    assert_load_follow_R2: assert property (@(posedge clk) disable iff (!armed)
        !load_n |-> (stage_q == par_in));

    assert_shift_step_R3: assert property (@(posedge clk) disable iff (!armed)
        (load_n && !clk_inhibit) |=>
            (!load_n || stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

    assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (!armed)
        (load_n && clk_inhibit) |=> (!load_n || $stable(stage_q)));

    assert_complement_R6: assert property (@(posedge clk) disable iff (!armed)
        q_out_n == ~q_out);

    assert_release_keep_R7: assert property (@(posedge clk) disable iff (!armed)
        $rose(load_n) |-> (stage_q == $past(par_in)));
endmodule

bind par_ser_shifter psr_checker #(.WIDTH(WIDTH)) u_psr_checker (
    .clk        (clk),
    .clk_inhibit(clk_inhibit),
    .load_n     (load_n),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .stage_q    (stage_q),
    .q_out      (q_out),
    .q_out_n    (q_out_n)
);

// File: tb/par_ser_shifter_bench.sv
module par_ser_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int SHIFTS = 10;

    logic         clk = 1'b0;
    logic         clk_inhibit = 1'b0;
    logic         load_n = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         q_out;
    logic         q_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    par_ser_shifter #(.WIDTH(W)) u_par_ser_shifter (
        .clk        (clk),
        .clk_inhibit(clk_inhibit),
        .load_n     (load_n),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .q_out      (q_out),
        .q_out_n    (q_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pair(input string req, input logic exp);
        check_bit(req, q_out, exp);
        check_bit("R6", q_out_n, ~exp);
    endtask

    initial begin
        int cycles = 0;
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] spat;
        logic         cur_ser;
        logic         cur_inh;
        for (int p = 0; p < 256; p++) begin
            // Load while the clock is high, check before the next edge (R1).
            @(posedge clk); #2;
            load_n = 1'b0; clk_inhibit = 1'b0; par_in = W'(p); ser_in = ~ser_in;
            #5 check_pair("R1", par_in[W-1]);
            // Edge passes while loading; word changes mid-load (R2).
            @(posedge clk); #2;
            par_in = ~W'(p); ser_in = ~ser_in;
            #5 check_pair("R2", ~W'(p) >> (W-1));
            @(posedge clk); #2;
            par_in = W'(p); ser_in = ~ser_in;
            #5 check_pair("R2", par_in[W-1]);
            // Release while the clock is high; nothing moves yet (R7).
            spat = W'((p * 37 + 11) & 8'hFF);
            @(posedge clk); #2;
            load_n = 1'b1;
            cur_ser = spat[0];
            cur_inh = ((p % 3) == 0);
            ser_in = cur_ser; clk_inhibit = cur_inh;
            par_in = W'(p ^ 8'h5A);
            model = W'(p);
            #5 check_pair("R7", model[W-1]);
            for (int k = 0; k < SHIFTS; k++) begin
                @(posedge clk);
                if (!cur_inh) model = {model[W-2:0], cur_ser};
                #2;
                cur_ser = spat[(k + 1) % W];
                cur_inh = (((p + k + 1) % 3) == 0);
                ser_in = cur_ser; clk_inhibit = cur_inh;
                par_in = W'((k * 29) ^ p); // ignored while shifting (R4)
                #5;
                if (((p + k) % 3) == 0) check_pair("R5", model[W-1]);
                else check_pair("R3/R4", model[W-1]);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule